// File: doc/BRIEF.md
# Vector Chaining Controller

This block sequences instructions into three vector functional units: a load unit, a multiply unit and an add unit. All three share one vector register file. Each unit handles one element per cycle. An element read in one cycle is written back a fixed number of cycles later, and every unit has its own latency. After writing its last element, a unit stays unavailable for a fixed recovery time.

A scoreboard keeps two items for each vector register: a bit that is set while an in-flight instruction still has to write the register, and a count of the elements written so far. With forwarding enabled, a dependent instruction reads element i of a source once that count exceeds i. It therefore runs a few cycles behind its producer and does not wait for the producer to finish. With forwarding disabled, the dependent instruction waits until the producer has written its final element. The disabled mode is kept so the two schedules can be compared. The controller makes the issue decision, gates each element read and reports every read and write. The arithmetic itself lives outside the block.

Top module: `vec_chain_ctrl`

## Requirements
- R1: While reset is held and right after it, no unit is busy, no read or write strobe is active, and an instruction for any valid unit with no hazard is accepted.
- R2: At most one instruction is accepted per cycle. An instruction whose unit is busy (running or recovering) is held. Op encoding on `issue_op_i`: 0 load, 1 multiply, 2 add.
- R3: An instruction is held while its destination register is still to be written by an in-flight instruction, or still has elements to be read by an in-flight multiply or add.
- R4: With `chain_en_i` high, a multiply or add reads element i of each source once that source has no pending producer, or once the source's written-element count exceeds i. Otherwise the read stalls that cycle.
- R5: With `chain_en_i` low, a multiply or add reads nothing from a source until that source's producer has written its last element.
- R6: A unit writes each element exactly its latency after reading it (load 3, multiply 4, add 2 cycles with the default parameters). The write carries the same index and the instruction's destination register. Elements go in ascending order.
- R7: After its last write, a unit stays busy for exactly the recovery time (2 cycles by default) before it accepts a new instruction.
- R8: When an instruction is accepted, its destination's written-element count restarts at zero. No count ever exceeds the maximum vector length.
- R9: The vector length is sampled at acceptance. Elements 0 to length-1 are each read exactly once, in order.
- R10: Op code 3 is reserved and is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_en_i | input | 1 | 1: element-wise forwarding; 0: wait for whole source |
| issue_valid_i | input | 1 | Instruction offered |
| issue_op_i | input | 2 | 0 load, 1 multiply, 2 add, 3 reserved |
| issue_vd_i | input | RW | Destination register |
| issue_vs1_i | input | RW | First source register (multiply/add) |
| issue_vs2_i | input | RW | Second source register (multiply/add) |
| vl_i | input | LW | Vector length, 1 to VLMAX |
| issue_ready_o | output | 1 | Offered instruction accepted this cycle when valid |
| unit_busy_o | output | 3 | Per unit: running or recovering (bit 0 load) |
| rd_en_o | output | 3 | Per unit: element read this cycle |
| rd_idx_o | output | 3xLW | Per unit: index being read |
| wr_en_o | output | 3 | Per unit: element write this cycle |
| wr_reg_o | output | 3xRW | Per unit: register being written |
| wr_idx_o | output | 3xLW | Per unit: element index being written |

## Verification
The assertions assume that every accepted vector length lies between 1 and VLMAX. They also assume that a multiply or add never names its own destination as a source, since the reset count would then block its reads forever. The stimulus draws lengths only from that range and picks sources that differ from the destination, including in the randomised sequences. The reserved op code is offered only on its own, and the bench withdraws it after a few cycles.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_MUL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam int N_UNITS = 3;
endpackage

// File: rtl/vcc_unit.sv
module vcc_unit #(
  parameter int RW   = 3,
  parameter int LW   = 5,
  parameter int LAT  = 3,
  parameter int DEAD = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] vd_i,
  input  logic [RW-1:0] vs1_i,
  input  logic [RW-1:0] vs2_i,
  input  logic [LW-1:0] vl_i,
  input  logic          src_ok_i,
  output logic          busy_o,
  output logic          reading_o,
  output logic          rd_en_o,
  output logic [LW-1:0] rd_idx_o,
  output logic [RW-1:0] vd_o,
  output logic [RW-1:0] vs1_o,
  output logic [RW-1:0] vs2_o,
  output logic          wr_en_o,
  output logic [LW-1:0] wr_idx_o,
  output logic          wr_last_o
);
  typedef enum logic [1:0] {U_IDLE, U_RUN, U_DEAD} st_e;
  localparam int DW = (DEAD > 1) ? $clog2(DEAD) : 1;

  st_e                   st_q;
  logic [RW-1:0]         vd_q, vs1_q, vs2_q;
  logic [LW-1:0]         vl_q, rd_q;
  logic [LAT-1:0]        pv_q;
  logic [LAT-1:0][LW-1:0] pi_q;
  logic [DW-1:0]         dc_q;

  assign busy_o    = (st_q != U_IDLE);
  assign reading_o = (st_q == U_RUN) && (rd_q < vl_q);
  assign rd_en_o   = reading_o && src_ok_i;
  assign rd_idx_o  = rd_q;
  assign vd_o      = vd_q;
  assign vs1_o     = vs1_q;
  assign vs2_o     = vs2_q;
  assign wr_en_o   = pv_q[LAT-1];
  assign wr_idx_o  = pi_q[LAT-1];
  assign wr_last_o = wr_en_o && (wr_idx_o == LW'(vl_q - 1'b1));

  // element pipeline: read index travels LAT stages to the write port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= '0;
      pi_q <= '0;
    end else begin
      for (int i = LAT - 1; i > 0; i--) begin
        pv_q[i] <= pv_q[i-1];
        pi_q[i] <= pi_q[i-1];
      end
      pv_q[0] <= rd_en_o;
      pi_q[0] <= rd_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= U_IDLE;
      vd_q  <= '0;
      vs1_q <= '0;
      vs2_q <= '0;
      vl_q  <= '0;
      rd_q  <= '0;
      dc_q  <= '0;
    end else begin
      case (st_q)
        U_IDLE: if (start_i) begin
          st_q  <= U_RUN;
          vd_q  <= vd_i;
          vs1_q <= vs1_i;
          vs2_q <= vs2_i;
          vl_q  <= vl_i;
          rd_q  <= '0;
        end
        U_RUN: begin
          if (rd_en_o) rd_q <= rd_q + 1'b1;
          if (wr_last_o) begin
            if (DEAD == 0) st_q <= U_IDLE;
            else begin
              st_q <= U_DEAD;
              dc_q <= DW'(DEAD - 1);
            end
          end
        end
        U_DEAD: begin
          if (dc_q == '0) st_q <= U_IDLE;
          else            dc_q <= dc_q - 1'b1;
        end
        default: st_q <= U_IDLE;
      endcase
    end
  end

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == U_IDLE)); // R2

  AST_WR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_last_o) |=> (!wr_en_o || wr_idx_o == LW'($past(wr_idx_o) + 1'b1))); // R6
endmodule

// File: rtl/vcc_scoreboard.sv
module vcc_scoreboard #(
  parameter int NR    = 8,
  parameter int RW    = 3,
  parameter int LW    = 5,
  parameter int VLMAX = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 claim_en_i,
  input  logic [RW-1:0]        claim_reg_i,
  input  logic [2:0]           wr_en_i,
  input  logic [2:0][RW-1:0]   wr_reg_i,
  input  logic [2:0]           wr_last_i,
  output logic [NR-1:0]        wbusy_o,
  output logic [NR-1:0][LW-1:0] cnt_o
);
  logic [NR-1:0] inc, done;

  always_comb begin
    inc  = '0;
    done = '0;
    for (int r = 0; r < NR; r++) begin
      for (int u = 0; u < 3; u++) begin
        if (wr_en_i[u] && wr_reg_i[u] == RW'(r)) begin
          inc[r]  = 1'b1;
          done[r] = done[r] | wr_last_i[u];
        end
      end
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wbusy_o[r] <= 1'b0;
        cnt_o[r]   <= '0;
      end else if (claim_en_i && claim_reg_i == RW'(r)) begin
        wbusy_o[r] <= 1'b1;
        cnt_o[r]   <= '0;
      end else begin
        if (inc[r])  cnt_o[r]   <= cnt_o[r] + 1'b1;
        if (done[r]) wbusy_o[r] <= 1'b0;
      end
    end

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o[r] <= LW'(VLMAX)); // R8
  end

  AST_CLAIM_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_en_i |-> !wbusy_o[claim_reg_i]); // R3
endmodule

// File: rtl/vec_chain_ctrl.sv
module vec_chain_ctrl
  import vcc_pkg::*;
#(
  parameter int NUM_VREGS = 8,
  parameter int VLMAX     = 16,
  parameter int LD_LAT    = 3,
  parameter int MUL_LAT   = 4,
  parameter int ADD_LAT   = 2,
  parameter int DEAD_CYC  = 2,
  localparam int RW = $clog2(NUM_VREGS),
  localparam int LW = $clog2(VLMAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chain_en_i,
  input  logic                issue_valid_i,
  input  logic [1:0]          issue_op_i,
  input  logic [RW-1:0]       issue_vd_i,
  input  logic [RW-1:0]       issue_vs1_i,
  input  logic [RW-1:0]       issue_vs2_i,
  input  logic [LW-1:0]       vl_i,
  output logic                issue_ready_o,
  output logic [2:0]          unit_busy_o,
  output logic [2:0]          rd_en_o,
  output logic [2:0][LW-1:0]  rd_idx_o,
  output logic [2:0]          wr_en_o,
  output logic [2:0][RW-1:0]  wr_reg_o,
  output logic [2:0][LW-1:0]  wr_idx_o
);
  logic [2:0]                 busy, reading, start, src_ok, wr_last;
  logic [2:0][RW-1:0]         vd_u, vs1_u, vs2_u;
  logic [NUM_VREGS-1:0]       wbusy;
  logic [NUM_VREGS-1:0][LW-1:0] cnt;
  logic                       unit_free, rd_haz, accept;

  function automatic logic fwd_ok(input logic [RW-1:0] s, input logic [LW-1:0] idx,
                                  input logic [NUM_VREGS-1:0] wb,
                                  input logic [NUM_VREGS-1:0][LW-1:0] c, input logic ch);
    return !wb[s] || (ch && (c[s] > idx));
  endfunction

  always_comb begin
    case (op_e'(issue_op_i))
      OP_LOAD: unit_free = !busy[0];
      OP_MUL:  unit_free = !busy[1];
      OP_ADD:  unit_free = !busy[2];
      default: unit_free = 1'b0;
    endcase
    rd_haz = 1'b0;
    for (int u = 1; u < 3; u++)
      if (reading[u] && (vs1_u[u] == issue_vd_i || vs2_u[u] == issue_vd_i)) rd_haz = 1'b1;
  end

  assign issue_ready_o = unit_free && !wbusy[issue_vd_i] && !rd_haz;
  assign accept        = issue_valid_i && issue_ready_o;
  assign unit_busy_o   = busy;

  for (genvar u = 0; u < 3; u++) begin : g_unit
    localparam int LAT = (u == 0) ? LD_LAT : ((u == 1) ? MUL_LAT : ADD_LAT);

    assign start[u] = accept && (issue_op_i == 2'(u));

    if (u == 0) begin : g_nosrc
      assign src_ok[u] = 1'b1;
    end else begin : g_src
      assign src_ok[u] = fwd_ok(vs1_u[u], rd_idx_o[u], wbusy, cnt, chain_en_i) &&
                         fwd_ok(vs2_u[u], rd_idx_o[u], wbusy, cnt, chain_en_i);

      AST_CHAIN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_o[u] |-> ((!wbusy[vs1_u[u]] || cnt[vs1_u[u]] > rd_idx_o[u]) &&
                        (!wbusy[vs2_u[u]] || cnt[vs2_u[u]] > rd_idx_o[u]))); // R4
      AST_NOCHAIN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_o[u] && !chain_en_i) |-> (!wbusy[vs1_u[u]] && !wbusy[vs2_u[u]])); // R5
    end

    vcc_unit #(.RW(RW), .LW(LW), .LAT(LAT), .DEAD(DEAD_CYC)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start[u]),
      .vd_i      (issue_vd_i),
      .vs1_i     (issue_vs1_i),
      .vs2_i     (issue_vs2_i),
      .vl_i      (vl_i),
      .src_ok_i  (src_ok[u]),
      .busy_o    (busy[u]),
      .reading_o (reading[u]),
      .rd_en_o   (rd_en_o[u]),
      .rd_idx_o  (rd_idx_o[u]),
      .vd_o      (vd_u[u]),
      .vs1_o     (vs1_u[u]),
      .vs2_o     (vs2_u[u]),
      .wr_en_o   (wr_en_o[u]),
      .wr_idx_o  (wr_idx_o[u]),
      .wr_last_o (wr_last[u])
    );
    assign wr_reg_o[u] = vd_u[u];
  end

  vcc_scoreboard #(.NR(NUM_VREGS), .RW(RW), .LW(LW), .VLMAX(VLMAX)) u_sb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .claim_en_i  (accept),
    .claim_reg_i (issue_vd_i),
    .wr_en_i     (wr_en_o),
    .wr_reg_i    (wr_reg_o),
    .wr_last_i   (wr_last),
    .wbusy_o     (wbusy),
    .cnt_o       (cnt)
  );

  AST_ONE_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start)); // R2
  AST_RSVD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_op_i == 2'd3) |-> (start == 3'b000)); // R10
endmodule

// File: tb/vec_chain_ctrl_tb.sv
module vec_chain_ctrl_tb;
  localparam int NR = 8, VLMAX = 16, RW = 3, LW = 5, DEAD = 2;
  localparam int LATS [3] = '{3, 4, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic chain_en = 1'b1, iv = 1'b0;
  logic [1:0] iop = '0;
  logic [RW-1:0] ivd = '0, is1 = '0, is2 = '0;
  logic [LW-1:0] ivl = 5'd1;
  logic ready;
  logic [2:0] busy, rd_en, wr_en;
  logic [2:0][LW-1:0] rd_idx, wr_idx;
  logic [2:0][RW-1:0] wr_reg;

  always #5 clk = ~clk;

  vec_chain_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain_en), .issue_valid_i(iv),
    .issue_op_i(iop), .issue_vd_i(ivd), .issue_vs1_i(is1), .issue_vs2_i(is2),
    .vl_i(ivl), .issue_ready_o(ready), .unit_busy_o(busy), .rd_en_o(rd_en),
    .rd_idx_o(rd_idx), .wr_en_o(wr_en), .wr_reg_o(wr_reg), .wr_idx_o(wr_idx));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_st[3], m_vd[3], m_s1[3], m_s2[3], m_vl[3], m_rd[3], m_dc[3];
  int m_pv[3][8];
  int wb[NR], cnt[NR];
  int q_op[$], q_vd[$], q_s1[$], q_s2[$], q_vl[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit srcok(int s, int idx);
    return (wb[s] == 0) || (chain_en && cnt[s] > idx);
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 3; u++) begin
      m_st[u] = 0; m_rd[u] = 0; m_vl[u] = 0; m_dc[u] = 0;
      m_vd[u] = 0; m_s1[u] = 0; m_s2[u] = 0;
      for (int i = 0; i < 8; i++) m_pv[u][i] = -1;
    end
    for (int r = 0; r < NR; r++) begin wb[r] = 0; cnt[r] = 0; end
  endtask

  // one cycle: inputs already driven; compare then advance the model
  task automatic step();
    bit rdy, haz, start;
    bit rden[3], wren[3], wlast[3];
    int widx[3];
    int op = int'(iop);
    #1;
    haz = 0;
    for (int u = 1; u < 3; u++)
      if (m_st[u] == 1 && m_rd[u] < m_vl[u] && (m_s1[u] == ivd || m_s2[u] == ivd)) haz = 1;
    rdy = (op < 3) && (op >= 0) && ((op < 3) ? (m_st[op < 3 ? op : 0] == 0) : 0)
          && wb[ivd] == 0 && !haz;
    chk(ready == rdy, (op == 3) ? "R10" : "R3", "issue_ready", ready, rdy);
    for (int u = 0; u < 3; u++) begin
      bit reading = (m_st[u] == 1) && (m_rd[u] < m_vl[u]);
      rden[u] = reading && (u == 0 || (srcok(m_s1[u], m_rd[u]) && srcok(m_s2[u], m_rd[u])));
      wren[u] = m_pv[u][LATS[u]-1] >= 0;
      widx[u] = m_pv[u][LATS[u]-1];
      wlast[u] = wren[u] && widx[u] == m_vl[u] - 1;
      chk(busy[u] == (m_st[u] != 0), "R7", $sformatf("busy[%0d]", u), busy[u], m_st[u] != 0);
      chk(rd_en[u] == rden[u], chain_en ? "R4" : "R5", $sformatf("rd_en[%0d]", u), rd_en[u], rden[u]);
      if (rden[u]) chk(int'(rd_idx[u]) == m_rd[u], "R9", $sformatf("rd_idx[%0d]", u), rd_idx[u], m_rd[u]);
      chk(wr_en[u] == wren[u], "R6", $sformatf("wr_en[%0d]", u), wr_en[u], wren[u]);
      if (wren[u]) begin
        chk(int'(wr_idx[u]) == widx[u], "R6", $sformatf("wr_idx[%0d]", u), wr_idx[u], widx[u]);
        chk(int'(wr_reg[u]) == m_vd[u], "R6", $sformatf("wr_reg[%0d]", u), wr_reg[u], m_vd[u]);
      end
    end
    start = iv && rdy;
    // scoreboard next state
    for (int u = 0; u < 3; u++)
      if (wren[u]) begin
        cnt[m_vd[u]]++;
        if (wlast[u]) wb[m_vd[u]] = 0;
      end
    if (start) begin wb[ivd] = 1; cnt[ivd] = 0; end
    for (int r = 0; r < NR; r++) chk(cnt[r] <= VLMAX, "R8", "count bound", cnt[r], VLMAX);
    // units next state
    for (int u = 0; u < 3; u++) begin
      for (int i = LATS[u] - 1; i > 0; i--) m_pv[u][i] = m_pv[u][i-1];
      m_pv[u][0] = rden[u] ? m_rd[u] : -1;
      case (m_st[u])
        0: if (start && op == u) begin
          m_st[u] = 1; m_vd[u] = ivd; m_s1[u] = is1; m_s2[u] = is2;
          m_vl[u] = ivl; m_rd[u] = 0;
        end
        1: begin
          if (rden[u]) m_rd[u]++;
          if (wlast[u]) begin m_st[u] = 2; m_dc[u] = DEAD - 1; end
        end
        default: if (m_dc[u] == 0) m_st[u] = 0; else m_dc[u]--;
      endcase
    end
    if (start && q_op.size() > 0) begin
      void'(q_op.pop_front()); void'(q_vd.pop_front()); void'(q_s1.pop_front());
      void'(q_s2.pop_front()); void'(q_vl.pop_front());
    end
    @(posedge clk);
    cyc++;
  endtask

  task automatic push(int op, int vd, int s1, int s2, int vl);
    q_op.push_back(op); q_vd.push_back(vd); q_s1.push_back(s1);
    q_s2.push_back(s2); q_vl.push_back(vl);
  endtask

  function automatic bit all_idle();
    return m_st[0] == 0 && m_st[1] == 0 && m_st[2] == 0;
  endfunction

  // runs the queued program; returns cycles taken
  task automatic run(bit ch, output int cycles);
    int t0 = cyc;
    @(negedge clk);
    chain_en = ch;
    while (q_op.size() > 0 || !all_idle()) begin
      if (q_op.size() > 0) begin
        iv = 1; iop = 2'(q_op[0]); ivd = RW'(q_vd[0]); is1 = RW'(q_s1[0]);
        is2 = RW'(q_s2[0]); ivl = LW'(q_vl[0]);
      end else iv = 0;
      step();
      @(negedge clk);
    end
    iv = 0;
    cycles = cyc - t0;
  endtask

  task automatic chain_prog();
    push(0, 1, 0, 0, 8);   // load v1
    push(0, 2, 0, 0, 8);   // load v2, waits for load unit (R2)
    push(1, 3, 1, 2, 8);   // mul v3 = v1*v2
    push(2, 5, 3, 4, 8);   // add v5 = v3+v4
  endtask

  initial begin
    int t_on, t_off, dummy;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 3'b000, "R1", "busy in reset", busy, 0);
    chk(wr_en == 3'b000 && rd_en == 3'b000, "R1", "strobes in reset", {wr_en, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    iop = 2'd2; ivd = 3'd7; is1 = 3'd0; is2 = 3'd1;
    #1;
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);

    chain_prog();
    run(1'b1, t_on);
    chain_prog();
    run(1'b0, t_off);
    chk(t_on < t_off, "R4", "forwarded chain finishes sooner", t_on, t_off);

    // write-after-read hold: load v1 while mul still reads v1 (R3)
    push(1, 3, 1, 2, 16);
    push(0, 1, 0, 0, 4);
    run(1'b1, dummy);
    // write-after-write hold (R3) and count restart (R8)
    push(0, 6, 0, 0, 4);
    push(2, 6, 1, 2, 5);
    push(1, 0, 6, 2, 5);
    run(1'b1, dummy);
    // length extremes (R9)
    push(0, 4, 0, 0, 1);
    push(2, 5, 4, 4 == 5 ? 0 : 3, 1);
    push(0, 7, 0, 0, VLMAX);
    push(1, 2, 7, 7, VLMAX);
    run(1'b1, dummy);
    run(1'b0, dummy);

    // reserved op held (R10)
    @(negedge clk);
    iv = 1; iop = 2'd3; ivd = 3'd2; ivl = 5'd4;
    for (int k = 0; k < 5; k++) begin step(); @(negedge clk); end
    iv = 0;

    // random programs, both modes
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 30; k++) begin
        int op = $urandom_range(0, 2);
        int vd = $urandom_range(0, NR - 1);
        int s1 = (vd + $urandom_range(1, NR - 1)) % NR;
        int s2 = (vd + $urandom_range(1, NR - 1)) % NR;
        push(op, vd, s1, s2, $urandom_range(1, VLMAX));
      end
      run(p[0], dummy);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule